// File: doc/BRIEF.md
# Chip-Select Wait-State Bus Controller

This block connects an on-chip master to an external 16-bit asynchronous memory bus that is divided into four chip-select areas. A request on the internal side carries a byte address, a read/write flag, two byte-lane enables and write data. The controller decodes the address into one of four 2 MB areas and runs one external bus cycle. During that cycle it drives a halfword address, a single active-low chip select, a read or write strobe and, on writes only, one active-low write strobe per byte lane. When the cycle ends it returns a response, which carries read data on reads.

Each area has its own wait setting from 0 to 7. An access lasts the programmed number of wait cycles plus one, and the strobes stay low for that whole time. Once the programmed count has run out, an active-low wait input from the device can stretch the access further. An area set to zero waits never looks at that input. Another bus master can take the external bus through an active-low hold request. The controller grants the bus only between accesses. While it holds the bus it floats its outputs and asserts an active-low hold acknowledge.

Both internal data paths use valid/ready handshakes. A request is accepted in the cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle and no hold is requested. There is one outstanding access at a time. The response is held with `rsp_valid` high and stable data until `rsp_ready` is seen. No new request is accepted before that happens, so back-pressure on the response stalls the request side.

Top module: `csbus_ctrl`

## Requirements
- R1: Address bits [31:21] with value 1, 2, 3 or 4 select area 0, 1, 2 or 3, and only that area's chip select (`ext_cs_n[area]`) goes low during the access. Any other value runs no external cycle: no chip select or strobe goes low, and a response with zero data is returned.
- R2: With `ext_wait_n` high, an access to an area programmed with W waits keeps its chip select and strobe low for exactly W+1 consecutive cycles.
- R3: For W greater than 0, `ext_wait_n` is sampled only once the programmed count has expired. Each cycle in which it is low at that point adds one cycle to the access. A low level during the first W cycles has no effect.
- R4: For an area programmed with zero waits, `ext_wait_n` is ignored and the access lasts exactly one cycle.
- R5: On writes, `ext_wr_n` is low, `ext_data_oe` is high and `ext_data_o` carries the write data. `ext_hi_n` (bits [15:8]) is low exactly when `req_be[1]` is set, and `ext_lo_n` (bits [7:0]) is low exactly when `req_be[0]` is set. On reads, `ext_rd_n` is low and both byte strobes and `ext_data_oe` stay inactive.
- R6: A read captures all 16 bits of `ext_data_i` in the last strobe cycle. In `rsp_rdata`, a lane whose `req_be` bit is clear returns zero. Writes return zero.
- R7: `ext_addr` carries halfword address bits [20:1] of the request during the access.
- R8: `rsp_valid` stays high with stable `rsp_rdata` until `rsp_ready` is sampled high. `req_ready` is low from acceptance until the response is taken.
- R9: A hold request (`ext_hold_req_n` low) sampled while idle makes the controller enter hold at the next edge. In hold, `ext_hold_ack_n` is low, `ext_bus_oe` is low, all strobes are high and no request is accepted. Hold ends at the edge after `ext_hold_req_n` is sampled high. A hold request takes priority over a pending internal request.
- R10: A hold request that arrives during an access or a pending response neither shortens nor ends that access. Hold is entered only after the response has been taken.
- R11: Between two accesses, the chip selects and strobes are all high for at least two consecutive cycles.
- R12: A write on the configuration port (`cfg_we`) sets the wait count of area `cfg_area` for accesses accepted afterwards. After reset, every area has 7 waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_addr | input | 32 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte lane enables, bit 1 = [15:8], bit 0 = [7:0] |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| cfg_we | input | 1 | Wait configuration write strobe |
| cfg_area | input | 2 | Area selected for configuration |
| cfg_wait | input | 3 | Wait count 0..7 |
| ext_addr | output | 20 | Halfword address within the area |
| ext_data_o | output | 16 | Write data to the bus |
| ext_data_oe | output | 1 | Data bus drive enable |
| ext_data_i | input | 16 | Read data from the bus |
| ext_cs_n | output | 4 | Active-low chip selects, one per area |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_wr_n | output | 1 | Active-low write strobe |
| ext_hi_n | output | 1 | Active-low upper byte write strobe |
| ext_lo_n | output | 1 | Active-low lower byte write strobe |
| ext_wait_n | input | 1 | Active-low wait request from device |
| ext_hold_req_n | input | 1 | Active-low bus hold request |
| ext_hold_ack_n | output | 1 | Active-low bus hold acknowledge |
| ext_bus_oe | output | 1 | Address/control drive enable, low while held |

## Verification
Some rules are checked by assertions on every cycle: at most one chip select is low, byte strobes stay quiet during reads, the bus is fully released in hold and hold begins only on an idle bus. They also check that strobes stay high for a second cycle after each release, that the wait counter steps down by one, that a zero-wait access ends after a single cycle, and that a stalled response keeps its data. Other behaviour needs the bench's scenarios, because it depends on the relation between the stimulus and the outcome. This covers the exact access length for each programmed count, including extra wait cycles and early wait pulses that must be ignored. It also covers the address-to-area mapping, the masking of read lanes, the default count after reset and a hold request raised in the middle of an access.

// File: rtl/csbus_pkg.sv
package csbus_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_RESP   = 2'd2,
    ST_HOLD   = 2'd3
  } bus_st_e;

endpackage

// File: rtl/csbus_decode.sv
module csbus_decode #(
  parameter int ADDR_W     = 32,
  parameter int AREA_LSB   = 21,
  parameter int N_AREA     = 4,
  parameter int FIRST_SLOT = 1,
  localparam int AREA_IW   = $clog2(N_AREA),
  localparam int SLOT_W    = ADDR_W - AREA_LSB
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic               hit_o,
  output logic [AREA_IW-1:0] area_o
);

  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] rel;
  logic              unused_low;

  assign slot       = addr_i[ADDR_W-1:AREA_LSB];
  assign rel        = slot - SLOT_W'(FIRST_SLOT);
  assign unused_low = ^addr_i[AREA_LSB-1:0];

  // An area is hit when the slot falls in [FIRST_SLOT, FIRST_SLOT+N_AREA)
  assign hit_o  = (slot >= SLOT_W'(FIRST_SLOT)) &&
                  (slot <  SLOT_W'(FIRST_SLOT + N_AREA));
  assign area_o = rel[AREA_IW-1:0];

endmodule

// File: rtl/csbus_waitcfg.sv
module csbus_waitcfg #(
  parameter int N_AREA   = 4,
  parameter int WAIT_W   = 3,
  localparam int AREA_IW = $clog2(N_AREA)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [AREA_IW-1:0] cfg_area,
  input  logic [WAIT_W-1:0]  cfg_wait,
  input  logic [AREA_IW-1:0] rd_area,
  output logic [WAIT_W-1:0]  rd_wait
);

  logic [WAIT_W-1:0] wait_q [N_AREA];

  for (genvar g = 0; g < N_AREA; g++) begin : g_area
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wait_q[g] <= '1;
      end else if (cfg_we && (cfg_area == AREA_IW'(g))) begin
        wait_q[g] <= cfg_wait;
      end
    end
  end

  assign rd_wait = wait_q[rd_area];

endmodule

// File: rtl/csbus_seq.sv
module csbus_seq
  import csbus_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int N_AREA   = 4,
  parameter int WAIT_W   = 3,
  parameter int AREA_LSB = 21,
  localparam int AREA_IW = $clog2(N_AREA),
  localparam int LANES   = DATA_W / 8,
  localparam int EXT_AW  = AREA_LSB - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [EXT_AW-1:0]  req_haddr,
  input  logic               req_write,
  input  logic [LANES-1:0]   req_be,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic               hit_i,
  input  logic [AREA_IW-1:0] area_i,
  input  logic [WAIT_W-1:0]  area_wait_i,
  input  logic               ext_wait_n,
  input  logic               ext_hold_req_n,
  input  logic [DATA_W-1:0]  ext_data_i,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [DATA_W-1:0]  rsp_rdata,
  output bus_st_e            st_o,
  output logic [AREA_IW-1:0] area_q,
  output logic               write_q,
  output logic [LANES-1:0]   be_q,
  output logic [EXT_AW-1:0]  haddr_q,
  output logic [DATA_W-1:0]  wdata_q
);

  bus_st_e           st;
  logic [WAIT_W-1:0] cnt;
  logic              zero_wait_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] lane_mask;
  logic              done;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_mask[g*8 +: 8] = {8{be_q[g]}};
  end

  // Device wait is only consulted once the programmed count is used up,
  // and never for zero-wait areas.
  assign done = (cnt == '0) && (zero_wait_q || ext_wait_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      cnt         <= '0;
      zero_wait_q <= 1'b0;
      rdata_q     <= '0;
      area_q      <= '0;
      write_q     <= 1'b0;
      be_q        <= '0;
      haddr_q     <= '0;
      wdata_q     <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (!ext_hold_req_n) begin
            st <= ST_HOLD;
          end else if (req_valid) begin
            haddr_q     <= req_haddr;
            write_q     <= req_write;
            be_q        <= req_be;
            wdata_q     <= req_wdata;
            area_q      <= area_i;
            rdata_q     <= '0;
            cnt         <= area_wait_i;
            zero_wait_q <= (area_wait_i == '0);
            st          <= hit_i ? ST_ACCESS : ST_RESP;
          end
        end
        ST_ACCESS: begin
          if (done) begin
            st <= ST_RESP;
            if (!write_q) rdata_q <= ext_data_i & lane_mask;
          end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_RESP: begin
          if (rsp_ready) st <= ST_IDLE;
        end
        ST_HOLD: begin
          if (ext_hold_req_n) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st == ST_IDLE) && ext_hold_req_n;
  assign rsp_valid = (st == ST_RESP);
  assign rsp_rdata = rdata_q;
  assign st_o      = st;

  // R4: a zero-wait access never lasts more than one cycle
  a_r4_zero_wait_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACCESS && zero_wait_q) |=> (st != ST_ACCESS));

  // R2: the programmed count steps down by one per cycle without ending the access
  a_r2_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACCESS && cnt != '0) |=> (st == ST_ACCESS && cnt == $past(cnt) - 1'b1));

  // R8: a stalled response keeps its data
  a_r8_rsp_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R8: no request is taken while one is outstanding
  a_r8_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACCESS || st == ST_RESP) |-> !req_ready);

endmodule

// File: rtl/csbus_ctrl.sv
module csbus_ctrl
  import csbus_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 16,
  parameter int N_AREA     = 4,
  parameter int WAIT_W     = 3,
  parameter int AREA_LSB   = 21,
  parameter int FIRST_SLOT = 1,
  localparam int AREA_IW   = $clog2(N_AREA),
  localparam int LANES     = DATA_W / 8,
  localparam int EXT_AW    = AREA_LSB - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               req_write,
  input  logic [LANES-1:0]   req_be,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [DATA_W-1:0]  rsp_rdata,
  input  logic               cfg_we,
  input  logic [AREA_IW-1:0] cfg_area,
  input  logic [WAIT_W-1:0]  cfg_wait,
  output logic [EXT_AW-1:0]  ext_addr,
  output logic [DATA_W-1:0]  ext_data_o,
  output logic               ext_data_oe,
  input  logic [DATA_W-1:0]  ext_data_i,
  output logic [N_AREA-1:0]  ext_cs_n,
  output logic               ext_rd_n,
  output logic               ext_wr_n,
  output logic               ext_hi_n,
  output logic               ext_lo_n,
  input  logic               ext_wait_n,
  input  logic               ext_hold_req_n,
  output logic               ext_hold_ack_n,
  output logic               ext_bus_oe
);

  logic               dec_hit;
  logic [AREA_IW-1:0] dec_area;
  logic [WAIT_W-1:0]  dec_wait;
  bus_st_e            st;
  logic [AREA_IW-1:0] area_q;
  logic               write_q;
  logic [LANES-1:0]   be_q;
  logic [EXT_AW-1:0]  haddr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic               acc;

  csbus_decode #(
    .ADDR_W(ADDR_W), .AREA_LSB(AREA_LSB), .N_AREA(N_AREA), .FIRST_SLOT(FIRST_SLOT)
  ) u_decode (
    .addr_i(req_addr), .hit_o(dec_hit), .area_o(dec_area)
  );

  csbus_waitcfg #(
    .N_AREA(N_AREA), .WAIT_W(WAIT_W)
  ) u_waitcfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_area(cfg_area),
    .cfg_wait(cfg_wait), .rd_area(dec_area), .rd_wait(dec_wait)
  );

  csbus_seq #(
    .DATA_W(DATA_W), .N_AREA(N_AREA), .WAIT_W(WAIT_W), .AREA_LSB(AREA_LSB)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_haddr(req_addr[AREA_LSB-1:1]), .req_write(req_write),
    .req_be(req_be), .req_wdata(req_wdata),
    .hit_i(dec_hit), .area_i(dec_area), .area_wait_i(dec_wait),
    .ext_wait_n(ext_wait_n), .ext_hold_req_n(ext_hold_req_n),
    .ext_data_i(ext_data_i),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .st_o(st), .area_q(area_q), .write_q(write_q), .be_q(be_q),
    .haddr_q(haddr_q), .wdata_q(wdata_q)
  );

  assign acc = (st == ST_ACCESS);

  for (genvar g = 0; g < N_AREA; g++) begin : g_cs
    assign ext_cs_n[g] = !(acc && (area_q == AREA_IW'(g)));
  end

  assign ext_rd_n       = !(acc && !write_q);
  assign ext_wr_n       = !(acc && write_q);
  assign ext_hi_n       = !(acc && write_q && be_q[LANES-1]);
  assign ext_lo_n       = !(acc && write_q && be_q[0]);
  assign ext_data_oe    = acc && write_q;
  assign ext_data_o     = wdata_q;
  assign ext_addr       = haddr_q;
  assign ext_hold_ack_n = (st != ST_HOLD);
  assign ext_bus_oe     = (st != ST_HOLD);

  // R1: never more than one chip select active
  a_r1_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ext_cs_n));

  // R5: byte write strobes are quiet during reads, and read/write never overlap
  a_r5_read_no_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_rd_n |-> (ext_hi_n && ext_lo_n && ext_wr_n && !ext_data_oe));

  // R9: bus fully released while held
  a_r9_hold_release: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_hold_ack_n |-> ((&ext_cs_n) && ext_rd_n && ext_wr_n && !ext_bus_oe && !req_ready));

  // R10: hold is only granted on an idle bus
  a_r10_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_hold_ack_n) |-> $past(&ext_cs_n));

  // R11: after a chip select releases, all stay high one more cycle
  a_r11_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(&ext_cs_n) |=> (&ext_cs_n));

endmodule

// File: tb/csbus_ctrl_tb.sv
module csbus_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [15:0] rsp_rdata;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_area = '0;
  logic [2:0]  cfg_wait = '0;
  logic [19:0] ext_addr;
  logic [15:0] ext_data_o;
  logic        ext_data_oe;
  logic [15:0] ext_data_i = '0;
  logic [3:0]  ext_cs_n;
  logic        ext_rd_n, ext_wr_n, ext_hi_n, ext_lo_n;
  logic        ext_wait_n = 1'b1;
  logic        ext_hold_req_n = 1'b1;
  logic        ext_hold_ack_n;
  logic        ext_bus_oe;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int waits [4];

  always #10 clk = ~clk;

  csbus_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .cfg_we(cfg_we), .cfg_area(cfg_area), .cfg_wait(cfg_wait),
    .ext_addr(ext_addr), .ext_data_o(ext_data_o), .ext_data_oe(ext_data_oe),
    .ext_data_i(ext_data_i), .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n),
    .ext_wr_n(ext_wr_n), .ext_hi_n(ext_hi_n), .ext_lo_n(ext_lo_n),
    .ext_wait_n(ext_wait_n), .ext_hold_req_n(ext_hold_req_n),
    .ext_hold_ack_n(ext_hold_ack_n), .ext_bus_oe(ext_bus_oe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int area_of(input logic [31:0] a);
    int s = int'(a[31:21]);
    return (s >= 1 && s <= 4) ? s - 1 : -1;
  endfunction

  function automatic int exp_len(input int area, input int w, input int extra);
    if (area < 0) return 0;
    if (w == 0) return 1;
    return w + 1 + extra;
  endfunction

  function automatic logic [15:0] exp_rdata(input logic wr, input logic [1:0] be,
                                            input logic [15:0] d);
    if (wr) return 16'h0;
    return d & {{8{be[1]}}, {8{be[0]}}};
  endfunction

  // R11: gap monitor on the pins
  int  hi_run = 0;
  bit  seen_access = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (&ext_cs_n) begin
        hi_run++;
      end else begin
        if (hi_run > 0 && seen_access)
          chk(hi_run >= 2, "R11", "strobe-high cycles between accesses", hi_run, 2);
        if (hi_run > 0) seen_access = 1;
        hi_run = 0;
      end
    end
  end

  task automatic set_wait(input int area, input int w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_area = 2'(area); cfg_wait = 3'(w);
    @(negedge clk);
    cfg_we = 1'b0;
    waits[area] = w;
  endtask

  task automatic run_access(input logic [31:0] addr, input logic wr, input logic [1:0] be,
                            input logic [15:0] wd, input int extra, input bit hold_mid,
                            input int rdly);
    int area = area_of(addr);
    int w = (area >= 0) ? waits[area] : 0;
    int n = 0;
    logic [15:0] last_d = '0;
    bit bad_cs = 0, bad_strb = 0, bad_addr = 0, bad_ack = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_write = wr; req_be = be; req_wdata = wd;
    chk(req_ready == 1'b1, "R8", "req_ready while idle", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    while (ext_cs_n != 4'hF && n < 40) begin
      n++;
      if (ext_cs_n != ~(4'b1 << area)) bad_cs = 1;
      if (ext_rd_n != wr || ext_wr_n != !wr || ext_data_oe != wr ||
          ext_hi_n != !(wr && be[1]) || ext_lo_n != !(wr && be[0]) ||
          (wr && ext_data_o != wd)) bad_strb = 1;
      if (ext_addr != addr[20:1]) bad_addr = 1;
      if (hold_mid && !ext_hold_ack_n) bad_ack = 1;
      if (n > w && n <= w + extra) ext_wait_n = 1'b0;
      else if (n <= w) ext_wait_n = 1'($urandom % 2);
      else ext_wait_n = 1'b1;
      if (hold_mid && n == 2) ext_hold_req_n = 1'b0;
      last_d = 16'($urandom);
      ext_data_i = last_d;
      @(negedge clk);
    end
    ext_wait_n = 1'b1;
    chk(n == exp_len(area, w, extra), (area < 0) ? "R1" : (w == 0 ? "R4" : "R2/R3"),
        "strobe cycles", n, exp_len(area, w, extra));
    if (n > 0) begin
      chk(!bad_cs, "R1", "chip select for area", area, area);
      chk(!bad_strb, "R5", "strobe/lane pattern", {wr, be}, {wr, be});
      chk(!bad_addr, "R7", "halfword address", ext_addr, addr[20:1]);
    end
    chk(rsp_valid == 1'b1, "R8", "rsp_valid after access", rsp_valid, 1);
    chk(rsp_rdata == exp_rdata(wr, be, last_d), "R6", "response data",
        rsp_rdata, exp_rdata(wr, be, last_d));
    for (int k = 0; k < rdly; k++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_rdata == exp_rdata(wr, be, last_d) && !req_ready,
          "R8", "held response", rsp_rdata, exp_rdata(wr, be, last_d));
    end
    if (hold_mid)
      chk(!bad_ack && ext_hold_ack_n, "R10", "ack during access/response", 0, 1);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(rsp_valid == 1'b0, "R8", "rsp_valid drops after accept", rsp_valid, 0);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = int'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) waits[i] = 7;
    repeat (3) @(negedge clk);
    chk(ext_cs_n == 4'hF && ext_rd_n && ext_wr_n && ext_hold_ack_n && !rsp_valid,
        "R9", "outputs in reset", {ext_cs_n, ext_rd_n, ext_wr_n}, 6'h3F);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && ext_bus_oe && ext_hi_n && ext_lo_n && !ext_data_oe,
        "R8", "idle after reset", {req_ready, ext_bus_oe}, 2'b11);

    // R12: default count of 7 for every area
    run_access(32'h0020_0010, 1'b0, 2'b11, 16'h0, 0, 0, 0);
    run_access(32'h0080_1234, 1'b1, 2'b10, 16'hA55A, 0, 0, 1);

    // R12/R4: zero waits, device wait ignored
    set_wait(1, 0);
    run_access(32'h0040_0002, 1'b1, 2'b01, 16'h1234, 3, 0, 0);
    run_access(32'h0040_0104, 1'b0, 2'b01, 16'h0, 2, 0, 2);

    // R3: extension after a count of 2, early pulses ignored
    set_wait(2, 2);
    run_access(32'h0060_0ffe, 1'b0, 2'b10, 16'h0, 3, 0, 0);

    // R1: outside all areas
    run_access(32'h0000_1000, 1'b0, 2'b11, 16'h0, 0, 0, 1);
    run_access(32'h00A0_0000, 1'b1, 2'b11, 16'hFFFF, 0, 0, 0);

    // R9: hold while idle, with a pending request
    @(negedge clk);
    ext_hold_req_n = 1'b0; req_valid = 1'b1; req_addr = 32'h0020_0000;
    @(negedge clk);
    chk(!ext_hold_ack_n && !ext_bus_oe && !req_ready && ext_cs_n == 4'hF,
        "R9", "hold entered over pending request", ext_hold_ack_n, 0);
    repeat (3) @(negedge clk);
    chk(ext_cs_n == 4'hF && !rsp_valid, "R9", "no access during hold", ext_cs_n, 4'hF);
    req_valid = 1'b0;
    ext_hold_req_n = 1'b1;
    @(negedge clk);
    chk(ext_hold_ack_n && ext_bus_oe, "R9", "hold released", ext_hold_ack_n, 1);

    // R10: hold request in the middle of an access
    set_wait(3, 5);
    run_access(32'h0080_0040, 1'b1, 2'b11, 16'hBEEF, 1, 1, 2);
    @(negedge clk);
    chk(!ext_hold_ack_n && !ext_bus_oe, "R10", "hold after response taken", ext_hold_ack_n, 0);
    ext_hold_req_n = 1'b1;
    @(negedge clk);

    // Random mix
    for (int it = 0; it < 60; it++) begin
      int a = int'($urandom % 5);
      logic [31:0] ad;
      if ($urandom % 3 == 0 && a < 4) set_wait(a, int'($urandom % 8));
      if (a < 4) ad = {11'(a + 1), 21'($urandom)};
      else ad = {($urandom % 2) ? 11'h000 : 11'h7FF, 21'($urandom)};
      run_access(ad, 1'($urandom), 2'($urandom), 16'($urandom),
                 int'($urandom % 3), 0, int'($urandom % 3));
    end

    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule